// File: doc/BRIEF.md
# Block-Streaming Storage Reader

This block loads audio data from a block storage device into a downstream request queue. Once reset is released and the device reports ready, it requests 512-byte blocks one after another. It numbers the blocks from zero and counts the bytes the device returns. It pairs the bytes into 16-bit words and hands each payload word to the queue with a one-cycle valid pulse.

The stored data is split into files by 32-bit separator words. One separator opens a file, one closes it, and one ends the stored data. Separators are removed from the stream. The first payload word of every file carries a new-file flag. After the end-of-data separator the reader stops for good.

Before it requests a block, the reader checks that the queue has room for a whole block of words. It waits as long as the room is missing.

The device side is slower than the block clock. Its byte strobe reaches the block already retimed to the block clock, and one strobe may stay high for several cycles.

Top module: `blockStreamReader`

## Requirements
- R1: After reset, no block read is requested until `devReady` is high. Every `devReadGo` pulse follows a cycle in which `devReady` was high.
- R2: A read request is a one-cycle `devReadGo` pulse with `devBlockAddr` naming the block. Block addresses start at 0 and rise by one per block. After a request, exactly 512 byte strobes are taken before the next request can be made.
- R3: The separators are 0xDEADBEEF (file start), 0xCAFED00D (file end) and 0xFEE1DEAD (end of data). Each separator is aligned to a 16-bit word boundary and its bytes arrive most significant first. Each is recognised from two consecutive words and is not forwarded. A word that merely equals one half of a separator is forwarded as payload.
- R4: A read is requested only if the queue has room for a full block, that is, if `queueCount` + 256 <= 1024 (the default depth). Otherwise the reader waits until `queueCount` falls far enough.
- R5: Two consecutive bytes form one word, and the first byte goes to bits [15:8]. `wordValid` is a one-cycle pulse. A payload word is released when the next word of the stream completes.
- R6: `wordNewFile` is high together with `wordValid` on the first payload word after each file-start separator, and low on all other words.
- R7: After the end-of-data separator, `loadDone` goes high and stays high. No further read is requested, no further word is produced, and later byte strobes have no effect.
- R8: A byte strobe that stays high for several cycles counts as one byte. Bytes are taken on the rising edge of the strobe.
- R9: During reset, `devReadGo`, `wordValid`, `wordNewFile` and `loadDone` are low and `devBlockAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReady | input | 1 | Storage device ready to accept a read |
| devByteStrobe | input | 1 | Byte strobe, retimed to the block clock; a rising edge marks a new byte |
| devByte | input | 8 | Byte returned by the device |
| queueCount | input | QCNT_W (11) | Number of entries in the downstream queue |
| devReadGo | output | 1 | One-cycle pulse that requests a block read |
| devBlockAddr | output | ADDR_W (32) | Index of the requested block |
| wordValid | output | 1 | One-cycle pulse: a payload word is presented |
| wordData | output | 16 | Payload word |
| wordNewFile | output | 1 | Marks the first payload word of a file |
| loadDone | output | 1 | End of stored data reached |

## Verification
The bench streams three files across three blocks. The separators fall inside blocks and the payload crosses block boundaries, so a reader that lost its pending word or byte half at a block edge would drop or shift words. The payload holds a lone 0xDEAD word that is not followed by 0xBEEF. A detector that matched on only half of a separator would swallow that word. Strobes are held high for up to three cycles, so a level-sensitive byte capture would duplicate bytes and scramble every later word. The queue count is held at exactly one entry above the limit and then at the limit. The reader then stops at the end of the data and ignores the rest of the last block. An off-by-one room test, a reader that read past the end, or one that took the trailing bytes would show up as an early or extra read request or as extra words.

// File: rtl/streamReaderPkg.sv
package streamReaderPkg;

  localparam logic [31:0] SEP_FILE_OPEN  = 32'hDEADBEEF;
  localparam logic [31:0] SEP_FILE_CLOSE = 32'hCAFED00D;
  localparam logic [31:0] SEP_DATA_END   = 32'hFEE1DEAD;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_XFER,
    ST_DONE
  } readState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeByte;
  } ctlStrobe_t;

endpackage

// File: rtl/readerCtl.sv
module readerCtl
  import streamReaderPkg::*;
#(
  parameter int QUEUE_DEPTH = 1024,
  parameter int BLOCK_BYTES = 512,
  parameter int ADDR_W      = 32,
  localparam int QCNT_W     = $clog2(QUEUE_DEPTH + 1),
  localparam int BCNT_W     = $clog2(BLOCK_BYTES),
  localparam int WORDS_PER_BLOCK = BLOCK_BYTES / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              devReady,
  input  logic              byteStrobe,
  input  logic [QCNT_W-1:0] queueCount,
  input  logic              hitEndData,
  output ctlStrobe_t        strobes,
  output logic              devReadGo,
  output logic [ADDR_W-1:0] devBlockAddr,
  output logic              loadDone
);

  readState_t        state;
  logic [BCNT_W-1:0] byteCnt;
  logic [ADDR_W-1:0] blockAddr;
  logic              strobeQ;
  logic              strobeEdge;
  logic [QCNT_W:0]   fillAfter;
  logic              roomOk;

  assign strobeEdge = byteStrobe & ~strobeQ;
  assign fillAfter  = {1'b0, queueCount} + (QCNT_W + 1)'(WORDS_PER_BLOCK);
  assign roomOk     = fillAfter <= (QCNT_W + 1)'(QUEUE_DEPTH);

  always_comb begin
    strobes          = '0;
    strobes.takeByte = (state == ST_XFER) && strobeEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      byteCnt   <= '0;
      blockAddr <= '0;
      strobeQ   <= 1'b0;
    end else begin
      strobeQ <= byteStrobe;
      unique case (state)
        ST_IDLE:  if (devReady) state <= ST_CHECK;
        ST_CHECK: if (devReady && roomOk) state <= ST_ISSUE;
        ST_ISSUE: begin
          byteCnt <= '0;
          state   <= ST_XFER;
        end
        ST_XFER: begin
          if (strobes.takeByte) begin
            if (hitEndData) begin
              state <= ST_DONE;
            end else if (byteCnt == BCNT_W'(BLOCK_BYTES - 1)) begin
              blockAddr <= blockAddr + 1'b1;
              state     <= ST_CHECK;
            end else begin
              byteCnt <= byteCnt + 1'b1;
            end
          end
        end
        ST_DONE:  state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign devReadGo    = (state == ST_ISSUE);
  assign devBlockAddr = blockAddr;
  assign loadDone     = (state == ST_DONE);

endmodule

// File: rtl/readerDp.sv
module readerDp
  import streamReaderPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  strobes,
  input  logic [7:0]  devByte,
  output logic        hitEndData,
  output logic        wordValid,
  output logic [15:0] wordData,
  output logic        wordNewFile
);

  logic [7:0]  hiByte;
  logic        haveHi;
  logic [15:0] pendWord;
  logic        pendValid;
  logic        pendFlag;
  logic        fileStartPend;

  logic [15:0] newWord;
  logic        wordDone;
  logic [31:0] window;
  logic        isOpen, isClose, isEnd, isSep;

  assign newWord  = {hiByte, devByte};
  assign wordDone = strobes.takeByte && haveHi;
  assign window   = {pendWord, newWord};
  assign isOpen   = pendValid && (window == SEP_FILE_OPEN);
  assign isClose  = pendValid && (window == SEP_FILE_CLOSE);
  assign isEnd    = pendValid && (window == SEP_DATA_END);
  assign isSep    = isOpen || isClose || isEnd;

  assign hitEndData = wordDone && isEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiByte        <= '0;
      haveHi        <= 1'b0;
      pendWord      <= '0;
      pendValid     <= 1'b0;
      pendFlag      <= 1'b0;
      fileStartPend <= 1'b0;
      wordValid     <= 1'b0;
      wordData      <= '0;
      wordNewFile   <= 1'b0;
    end else begin
      wordValid   <= 1'b0;
      wordNewFile <= 1'b0;
      if (strobes.takeByte && !haveHi) begin
        hiByte <= devByte;
        haveHi <= 1'b1;
      end else if (wordDone) begin
        haveHi <= 1'b0;
        if (isSep) begin
          pendValid <= 1'b0;
          if (isOpen) fileStartPend <= 1'b1;
        end else begin
          if (pendValid) begin
            wordValid   <= 1'b1;
            wordData    <= pendWord;
            wordNewFile <= pendFlag;
          end
          pendWord      <= newWord;
          pendValid     <= 1'b1;
          pendFlag      <= fileStartPend;
          fileStartPend <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/blockStreamReader.sv
module blockStreamReader
  import streamReaderPkg::*;
#(
  parameter int QUEUE_DEPTH = 1024,
  parameter int BLOCK_BYTES = 512,
  parameter int ADDR_W      = 32,
  localparam int QCNT_W     = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              devReady,
  input  logic              devByteStrobe,
  input  logic [7:0]        devByte,
  input  logic [QCNT_W-1:0] queueCount,
  output logic              devReadGo,
  output logic [ADDR_W-1:0] devBlockAddr,
  output logic              wordValid,
  output logic [15:0]       wordData,
  output logic              wordNewFile,
  output logic              loadDone
);

  ctlStrobe_t strobes;
  logic       hitEndData;

  readerCtl #(
    .QUEUE_DEPTH(QUEUE_DEPTH),
    .BLOCK_BYTES(BLOCK_BYTES),
    .ADDR_W     (ADDR_W)
  ) i_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .devReady    (devReady),
    .byteStrobe  (devByteStrobe),
    .queueCount  (queueCount),
    .hitEndData  (hitEndData),
    .strobes     (strobes),
    .devReadGo   (devReadGo),
    .devBlockAddr(devBlockAddr),
    .loadDone    (loadDone)
  );

  readerDp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .devByte    (devByte),
    .hitEndData (hitEndData),
    .wordValid  (wordValid),
    .wordData   (wordData),
    .wordNewFile(wordNewFile)
  );

endmodule

// File: rtl/readerChk.sv
module readerChk #(
  parameter int QUEUE_DEPTH = 1024,
  parameter int BLOCK_BYTES = 512,
  localparam int QCNT_W     = $clog2(QUEUE_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              devReady,
  input logic [QCNT_W-1:0] queueCount,
  input logic              devReadGo,
  input logic              wordValid,
  input logic              wordNewFile,
  input logic              loadDone
);

  localparam logic [QCNT_W-1:0] FILL_LIMIT = QCNT_W'(QUEUE_DEPTH - BLOCK_BYTES / 2);

  AST_GO_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    devReadGo |-> $past(devReady)); // R1

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    devReadGo |=> !devReadGo); // R2

  AST_GO_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    devReadGo |-> ($past(queueCount) <= FILL_LIMIT)); // R4

  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R5

  AST_FLAG_WITH_WORD: assert property (@(posedge clk) disable iff (!rstN)
    wordNewFile |-> wordValid); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (!wordValid && !devReadGo)); // R7

endmodule

bind blockStreamReader readerChk #(
  .QUEUE_DEPTH(QUEUE_DEPTH),
  .BLOCK_BYTES(BLOCK_BYTES)
) i_readerChk (
  .clk        (clk),
  .rstN       (rstN),
  .devReady   (devReady),
  .queueCount (queueCount),
  .devReadGo  (devReadGo),
  .wordValid  (wordValid),
  .wordNewFile(wordNewFile),
  .loadDone   (loadDone)
);

// File: tb/test_blockStreamReader.sv
module test_blockStreamReader;

  localparam int STREAM_LEN = 1536;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devReady = 1'b0;
  logic        devByteStrobe = 1'b0;
  logic [7:0]  devByte = 8'h00;
  logic [10:0] queueCount = 11'd0;
  logic        devReadGo;
  logic [31:0] devBlockAddr;
  logic        wordValid;
  logic [15:0] wordData;
  logic        wordNewFile;
  logic        loadDone;

  int checks = 0;
  int errors = 0;
  int goCount = 0;
  int wordCount = 0;
  int payloadTotal = 0;
  logic [31:0] lastAddr = '0;
  logic [7:0]  streamBytes [STREAM_LEN];
  logic [16:0] expQ [$];
  int wp = 0;

  always #5 clk = ~clk;

  blockStreamReader i_blockStreamReader (
    .clk(clk), .rstN(rstN), .devReady(devReady), .devByteStrobe(devByteStrobe),
    .devByte(devByte), .queueCount(queueCount), .devReadGo(devReadGo),
    .devBlockAddr(devBlockAddr), .wordValid(wordValid), .wordData(wordData),
    .wordNewFile(wordNewFile), .loadDone(loadDone)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic putWord(input logic [15:0] w);
    streamBytes[wp]     = w[15:8];
    streamBytes[wp + 1] = w[7:0];
    wp += 2;
  endtask

  task automatic putSep(input logic [31:0] s);
    putWord(s[31:16]);
    putWord(s[15:0]);
  endtask

  // Driver side: lays out a file and pushes expected payload into the scoreboard
  task automatic putFile(input int fileIdx, input int nWords, input int loneIdx);
    putSep(32'hDEADBEEF);
    for (int i = 0; i < nWords; i++) begin
      logic [15:0] w;
      w = (i == loneIdx) ? 16'hDEAD : 16'(16'h1000 + fileIdx * 16'h0400 + i);
      putWord(w);
      expQ.push_back({(i == 0), w});
      payloadTotal++;
    end
    putSep(32'hCAFED00D);
  endtask

  task automatic sendBlock(input int blk);
    @(negedge clk);
    for (int i = 0; i < 512; i++) begin
      devByte       = streamBytes[blk * 512 + i];
      devByteStrobe = 1'b1;
      repeat ((i % 3) + 1) @(negedge clk);  // R8: held strobe
      devByteStrobe = 1'b0;
      repeat ((i % 2) + 1) @(negedge clk);
    end
  endtask

  task automatic waitGo(input int n);
    int t = 0;
    while (goCount < n && t < 200) begin
      @(negedge clk);
      #1;
      t++;
    end
    check(goCount >= n, "R2 read request not seen", goCount, n);
  endtask

  // Monitor: counts requests and pops the scoreboard on every word
  always @(negedge clk) begin
    if (rstN) begin
      if (devReadGo) begin
        goCount++;
        lastAddr = devBlockAddr;
      end
      if (wordValid) begin
        wordCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R3/R7 unexpected word", {wordNewFile, wordData}, 0);
        end else begin
          logic [16:0] e;
          e = expQ.pop_front();
          check({wordNewFile, wordData} == e, "R3/R5/R6/R8 word or new-file flag",
                {wordNewFile, wordData}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < STREAM_LEN; i++) streamBytes[i] = 8'h00;
    putFile(0, 300, -1);
    putFile(1, 200, 10);   // lone 0xDEAD word, R3
    putFile(2, 150, -1);
    putSep(32'hFEE1DEAD);

    queueCount = 11'd1000;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(devReadGo == 1'b0, "R9 devReadGo in reset", devReadGo, 0);
    check(wordValid == 1'b0, "R9 wordValid in reset", wordValid, 0);
    check(wordNewFile == 1'b0, "R9 wordNewFile in reset", wordNewFile, 0);
    check(loadDone == 1'b0, "R9 loadDone in reset", loadDone, 0);
    check(devBlockAddr == 32'd0, "R9 devBlockAddr in reset", devBlockAddr, 0);

    rstN = 1'b1;
    queueCount = 11'd0;
    repeat (20) @(negedge clk);
    check(goCount == 0, "R1 request without ready", goCount, 0);

    devReady = 1'b1;
    queueCount = 11'd769;
    repeat (20) @(negedge clk);
    check(goCount == 0, "R4 request with 255 free entries", goCount, 0);

    queueCount = 11'd768;
    waitGo(1);
    check(lastAddr == 32'd0, "R2 first block address", lastAddr, 0);
    check(goCount == 1, "R4 request with exactly 256 free", goCount, 1);

    queueCount = 11'd900;
    sendBlock(0);
    repeat (20) @(negedge clk);
    check(goCount == 1, "R4 request while queue full", goCount, 1);

    queueCount = 11'd0;
    waitGo(2);
    check(lastAddr == 32'd1, "R2 second block address", lastAddr, 1);
    sendBlock(1);
    waitGo(3);
    check(lastAddr == 32'd2, "R2 third block address", lastAddr, 2);
    sendBlock(2);   // end-of-data inside, rest of block must be ignored (R7)

    repeat (20) @(negedge clk);
    check(loadDone == 1'b1, "R7 loadDone after end of data", loadDone, 1);
    check(goCount == 3, "R7 no read after end of data", goCount, 3);
    check(expQ.size() == 0, "R3 payload words missing", expQ.size(), 0);
    check(wordCount == payloadTotal, "R3 forwarded word count", wordCount, payloadTotal);

    for (int i = 0; i < 8; i++) begin
      devByte = 8'hA5;
      devByteStrobe = 1'b1;
      @(negedge clk);
      devByteStrobe = 1'b0;
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(wordCount == payloadTotal, "R7 strobes after done produced words", wordCount, payloadTotal);
    check(goCount == 3, "R7 strobes after done produced reads", goCount, 3);
    check(loadDone == 1'b1, "R7 loadDone sticky", loadDone, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule